// File: doc/BRIEF.md
# Fan PWM Generator

This block drives one fan-control PWM line. An 8-bit duty byte sets how long the line stays high in each period. A 3-bit frequency code sets the carrier rate. A prescaler divides the system clock into ticks, and a phase counter walks through 255 ticks per period. The output is high while the phase is below the active duty value. So a duty of FFh keeps the line high all the time, and 00h keeps it low all the time.

The duty byte and the frequency code are sampled only at a period boundary. Software can therefore rewrite either one at any moment without cutting a period short or stretching a pulse. A system with two fans uses one instance per fan, and each instance has its own duty and frequency inputs.

After reset the block behaves as if the duty were FFh and the code were 001, so a fan runs at full speed before software touches it. The parameter `TICK_DIV_BASE` (written B below) is the number of system clocks per tick for the fastest listed code. It is chosen so that code 001 gives about 23 kHz.

Top module: `fan_pwm_gen`

## Requirements
- R1: After reset the output is high. It stays high until a duty other than FFh has been applied at a period boundary. Reset uses duty FFh and code 001.
- R2: While the active duty is FFh, the output is high on every cycle.
- R3: While the active duty is 00h, the output is low on every cycle.
- R4: Each period lasts exactly 255 ticks. The output rises at the start of the period and stays high for exactly D ticks, where D is the active duty.
- R5: One tick lasts B system clocks for code 001, 2B for code 010, 4B for code 011 and 8B for code 100. Each step halves the carrier frequency.
- R6: Codes 000, 101, 110 and 111 give the same tick length as code 001.
- R7: A change of the duty input in the middle of a period does not alter the current period. The new value first applies from the next period start.
- R8: A change of the frequency code in the middle of a period does not alter the length of the current period. The new code first applies from the next period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dutyIn | input | DUTY_W (8) | Requested high time in ticks; FFh = always high, 00h = always low |
| freqSel | input | 3 | Carrier frequency code (001 fastest listed, 100 slowest) |
| pwmOut | output | 1 | Registered PWM output |

## Verification
On every cycle the assertions check four things:
- The phase counter stays inside its 255-tick range.
- The two extreme duty values force a constant output level.
- A rising output edge lines up with phase zero.
- The latched duty and the latched frequency code change only at phase zero.

Only the bench can show timing in system clocks. It measures the exact period and high time for every listed code and a spread of duty values, and checks that unlisted codes fall back to the default rate. It also measures the periods around mid-period rewrites of the duty and of the code.

// File: rtl/fan_pwm_pkg.sv
package fan_pwm_pkg;

  localparam int SEL_W = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;   // one tick of the selected rate has elapsed
    logic load;   // tick that ends a period: latch new settings
  } pwmStb_t;

  // Frequency code to prescaler shift; unlisted codes map to code 001
  function automatic logic [1:0] selToShift(input logic [SEL_W-1:0] code);
    case (code)
      3'b010:  return 2'd1;
      3'b011:  return 2'd2;
      3'b100:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
  import fan_pwm_pkg::*;
#(
  parameter int TICK_DIV_BASE = 33
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] freqSel,
  input  logic             periodEnd,
  output pwmStb_t          stb,
  output logic [1:0]       selAct
);

  localparam int MAX_DIV = TICK_DIV_BASE * 8;
  localparam int PRE_W   = $clog2(MAX_DIV + 1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divLim;
  logic             tickNow;

  assign divLim  = PRE_W'(TICK_DIV_BASE) << selAct;
  assign tickNow = (preCnt == divLim - PRE_W'(1));

  always_comb begin
    stb.tick = tickNow;
    stb.load = tickNow && periodEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      selAct <= 2'd0;
    end else begin
      if (tickNow) preCnt <= '0;
      else         preCnt <= preCnt + PRE_W'(1);
      if (stb.load) selAct <= selToShift(freqSel);
    end
  end

endmodule

// File: rtl/fan_pwm_dp.sv
module fan_pwm_dp
  import fan_pwm_pkg::*;
#(
  parameter int DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyIn,
  input  pwmStb_t           stb,
  output logic              periodEnd,
  output logic [DUTY_W-1:0] phase,
  output logic [DUTY_W-1:0] dutyAct,
  output logic              pwmOut
);

  localparam logic [DUTY_W-1:0] LAST_PHASE = {{(DUTY_W-1){1'b1}}, 1'b0};

  logic [DUTY_W-1:0] phaseNext;
  logic [DUTY_W-1:0] dutyNext;

  assign periodEnd = (phase == LAST_PHASE);

  always_comb begin
    phaseNext = phase;
    dutyNext  = dutyAct;
    if (stb.load) begin
      phaseNext = '0;
      dutyNext  = dutyIn;
    end else if (stb.tick) begin
      phaseNext = phase + DUTY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      dutyAct <= '1;
      pwmOut  <= 1'b1;
    end else begin
      phase   <= phaseNext;
      dutyAct <= dutyNext;
      pwmOut  <= (phaseNext < dutyNext);
    end
  end

endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pwm_pkg::*;
#(
  parameter int DUTY_W        = 8,
  parameter int TICK_DIV_BASE = 33
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DUTY_W-1:0] dutyIn,
  input  logic [SEL_W-1:0]  freqSel,
  output logic              pwmOut
);

  pwmStb_t           stb;
  logic              periodEnd;
  logic [1:0]        selAct;
  logic [DUTY_W-1:0] phase;
  logic [DUTY_W-1:0] dutyAct;

  fan_pwm_ctrl #(.TICK_DIV_BASE(TICK_DIV_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .freqSel(freqSel),
    .periodEnd(periodEnd), .stb(stb), .selAct(selAct)
  );

  fan_pwm_dp #(.DUTY_W(DUTY_W)) uDp (
    .clk(clk), .rstN(rstN), .dutyIn(dutyIn), .stb(stb),
    .periodEnd(periodEnd), .phase(phase), .dutyAct(dutyAct), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/fan_pwm_chk.sv
module fan_pwm_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              pwmOut,
  input logic [DUTY_W-1:0] phase,
  input logic [DUTY_W-1:0] dutyAct,
  input logic [1:0]        selAct
);

  localparam logic [DUTY_W-1:0] LAST_PHASE = {{(DUTY_W-1){1'b1}}, 1'b0};

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phase <= LAST_PHASE); // R4
  AST_FULL_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (dutyAct == '1) |-> pwmOut); // R2
  AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (dutyAct == '0) |-> !pwmOut); // R3
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmOut) |-> (phase == '0)); // R4
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dutyAct) |-> (phase == '0)); // R7
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selAct) |-> (phase == '0)); // R8

endmodule

bind fan_pwm_gen fan_pwm_chk #(.DUTY_W(DUTY_W)) uChk (
  .clk(clk), .rstN(rstN), .pwmOut(pwmOut),
  .phase(phase), .dutyAct(dutyAct), .selAct(selAct)
);

// File: tb/fan_pwm_gen_test.sv
module fan_pwm_gen_test;

  localparam int BASE = 1;
  localparam int TICKS = 255;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] dutyIn = 8'hFF;
  logic [2:0] freqSel = 3'b001;
  logic       pwmOut;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  fan_pwm_gen #(.DUTY_W(8), .TICK_DIV_BASE(BASE)) uut (
    .clk(clk), .rstN(rstN), .dutyIn(dutyIn), .freqSel(freqSel), .pwmOut(pwmOut)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unitOf(input logic [2:0] code);
    case (code)
      3'b010:  return 2 * BASE;
      3'b011:  return 4 * BASE;
      3'b100:  return 8 * BASE;
      default: return BASE;
    endcase
  endfunction

  task automatic waitEdge(input bit rising);
    logic p;
    bit   hit;
    p = pwmOut;
    hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      hit = rising ? (!p && pwmOut) : (p && !pwmOut);
      p = pwmOut;
    end
  endtask

  // From a rise sample, count one period; returns at the next rise sample
  task automatic countPeriod(output int per, output int hi);
    logic p;
    bit   hit;
    per = 1; hi = 1; p = 1'b1; hit = 1'b0;
    while (!hit) begin
      @(negedge clk);
      hit = !p && pwmOut;
      if (!hit) begin
        per++;
        if (pwmOut) hi++;
      end
      p = pwmOut;
    end
  endtask

  task automatic measure(input logic [7:0] d, input logic [2:0] c, input string req);
    int per, hi;
    dutyIn = d; freqSel = c;
    waitEdge(1'b0);
    waitEdge(1'b1);
    countPeriod(per, hi);
    check(req, per, TICKS * unitOf(c));
    check(req, hi, int'(d) * unitOf(c));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    while (!done) begin
      @(posedge clk);
      if (checks + errors > 1000000) break;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, hi, bad;
    logic [7:0] duties [5] = '{8'd1, 8'd2, 8'd127, 8'd128, 8'd254};
    repeat (3) @(negedge clk);
    check("R1 reset level", int'(pwmOut), 1);
    rstN = 1'b1;
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!pwmOut) bad++;
    end
    check("R1 default full speed", bad, 0);

    // R4 R5: every listed code against several duties
    for (int c = 1; c <= 4; c++)
      for (int k = 0; k < 5; k++)
        measure(duties[k], 3'(c), "R4 R5 period and high time");

    // R6: unlisted codes fall back to code 001 timing
    measure(8'd100, 3'b000, "R6 code 000");
    measure(8'd100, 3'b101, "R6 code 101");
    measure(8'd100, 3'b110, "R6 code 110");
    measure(8'd100, 3'b111, "R6 code 111");

    // R7: duty rewrite right after a period start
    measure(8'd200, 3'b001, "R7 setup");
    dutyIn = 8'd50;
    countPeriod(per, hi);
    check("R7 current period keeps old duty", hi, 200 * unitOf(3'b001));
    countPeriod(per, hi);
    check("R7 next period uses new duty", hi, 50 * unitOf(3'b001));

    // R8: code rewrite right after a period start
    measure(8'd100, 3'b001, "R8 setup");
    freqSel = 3'b011;
    countPeriod(per, hi);
    check("R8 current period keeps old rate", per, TICKS * unitOf(3'b001));
    countPeriod(per, hi);
    check("R8 next period uses new rate", per, TICKS * unitOf(3'b011));

    // R3: duty 00h, slowest code
    dutyIn = 8'h00; freqSel = 3'b100;
    repeat (2 * TICKS * 8 * BASE + 10) @(negedge clk);
    bad = 0;
    for (int i = 0; i < TICKS * 8 * BASE + 5; i++) begin
      @(negedge clk);
      if (pwmOut) bad++;
    end
    check("R3 zero duty always low", bad, 0);

    // R2: duty FFh
    dutyIn = 8'hFF;
    repeat (2 * TICKS * 8 * BASE + 10) @(negedge clk);
    bad = 0;
    for (int i = 0; i < TICKS * 8 * BASE + 5; i++) begin
      @(negedge clk);
      if (!pwmOut) bad++;
    end
    check("R2 full duty always high", bad, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule